// File: doc/BRIEF.md
# Negated Register-Count Offset Generator

This block takes a 16-bit register-select mask and produces the byte offset from a stack top down to the first word of a multi-register transfer. The offset is minus four times the number of set bits in the mask, as a sign-extended two's-complement word. The count comes from a tree of three-input full adders. The tree ends in a row of half adders that each add an extra one. Inverting that row's result turns the count directly into its negation, so no separate subtractor is needed.

The offset path is purely combinational from the mask. Control logic asserts a drive enable, and a two-state machine registers it. In state `ST_QUIET` the bus carries all zeros and the valid qualifier is low. In state `ST_DRIVE` the bus carries the offset and valid is high. The transition `QUIET_TO_DRIVE` is taken on a clock edge with the enable high, and `DRIVE_TO_QUIET` on a clock edge with it low. In every other case the state holds (`HOLD_QUIET`, `HOLD_DRIVE`). Reset forces `ST_QUIET`.

Top module: `popc_neg_offset`

## Requirements
- R1: During and right after reset (rst_n low), the machine is in ST_QUIET, so bus_o is 0 and bus_valid_o is 0.
- R2: The enable is registered. bus_valid_o becomes 1 at the first rising clock edge that samples drive_en_i high, and 0 at the first rising edge that samples it low. It never changes between edges.
- R3: Whenever bus_valid_o is 0, bus_o is all zeros, whatever mask_i holds.
- R4: Whenever bus_valid_o is 1, bus_o equals -(4 × number of ones in mask_i) as a 32-bit two's-complement value.
- R5: With a mask of all zeros while driving, bus_o is 0x00000000.
- R6: With a mask of all ones while driving, bus_o is 0xFFFFFFC0 (-64).
- R7: With exactly one mask bit set, at any of the 16 positions, bus_o is 0xFFFFFFFC (-4) while driving.
- R8: bus_o bits 1 and 0 are always 0 (the word offset is scaled by four).
- R9: bus_o bits 31 down to 6 are always all equal (sign extension of the 5-bit negated count placed at bit 2).
- R10: While driving, a change of mask_i reaches bus_o with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_i | input | 16 | Register-select mask; each set bit is one word |
| drive_en_i | input | 1 | Request from control logic to drive the bus |
| bus_o | output | 32 | Byte offset −4·count when driving, zero otherwise |
| bus_valid_o | output | 1 | High while bus_o carries the offset |

## Verification
The bench builds the block with a 32-bit bus and a scale shift of two, the sizes a 16-register, 4-byte-word machine uses. With these values the full signed range of the offset, from 0 down to -64, appears on the bus. The all-ones mask therefore reaches the single case where the top ripple carry and the sign bit must agree across all 26 upper bits. Single-bit masks walked over every position make each first-layer adder and the leftover bit carry the whole count alone. Changing the mask between clock edges shows that the offset path has no register in it, while the enable path has exactly one.

// File: rtl/popc_pkg.sv
`timescale 1ns/1ps
package popc_pkg;
    // Mask width is tied to the hand-built adder tree below.
    localparam int MASK_W = 16;
    // Count 0..16 needs five bits once negated.
    localparam int CNT_W  = 5;
    // Number of first-layer full adders consuming input triples.
    localparam int L1_N   = MASK_W / 3;
    // Number of weight columns closed by the increment half adders.
    localparam int COL_N  = CNT_W - 1;

    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_DRIVE = 1'b1
    } drv_state_e;
endpackage

// File: rtl/popc_fa.sv
`timescale 1ns/1ps
// Full adder built mux-style: the propagate term selects between paths.
module popc_fa (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic co_o
);
    logic prop;

    always_comb begin
        prop = a_i ^ b_i;
        s_o  = prop ? ~c_i : c_i;
        co_o = prop ? c_i  : a_i;
    end
endmodule

// File: rtl/popc_ha_inc.sv
`timescale 1ns/1ps
// Half adder that adds an implicit one: a + b + 1.
module popc_ha_inc (
    input  logic a_i,
    input  logic b_i,
    output logic s_o,
    output logic co_o
);
    always_comb begin
        s_o  = ~(a_i ^ b_i);
        co_o = a_i | b_i;
    end
endmodule

// File: rtl/popc_tree.sv
`timescale 1ns/1ps
// Reduces the mask to one bit per weight column (two at weight 1),
// then closes with increment half adders and inverts to get -count.
module popc_tree
    import popc_pkg::*;
(
    input  logic [MASK_W-1:0] mask_i,
    output logic [CNT_W-1:0]  neg_cnt_o
);
    logic [L1_N-1:0] l1_s;
    logic [L1_N-1:0] l1_c;

    // First layer: triples of mask bits.
    for (genvar g = 0; g < L1_N; g++) begin : g_l1
        popc_fa u_fa (
            .a_i (mask_i[3*g]),
            .b_i (mask_i[3*g+1]),
            .c_i (mask_i[3*g+2]),
            .s_o (l1_s[g]),
            .co_o(l1_c[g])
        );
    end

    logic w1_a, w1_b, w2_p, w2_q, w2_r, w2_s, w2_f;
    logic w4_p, w4_q, w4_r, w4_f, w8_f;

    // Weight-1 column: five sums plus the leftover top mask bit.
    popc_fa u_w1_a (.a_i(l1_s[0]), .b_i(l1_s[1]), .c_i(l1_s[2]),
                    .s_o(w1_a), .co_o(w2_p));
    popc_fa u_w1_b (.a_i(l1_s[3]), .b_i(l1_s[4]), .c_i(mask_i[MASK_W-1]),
                    .s_o(w1_b), .co_o(w2_q));
    // Weight-2 column: seven carries.
    popc_fa u_w2_a (.a_i(l1_c[0]), .b_i(l1_c[1]), .c_i(l1_c[2]),
                    .s_o(w2_r), .co_o(w4_p));
    popc_fa u_w2_b (.a_i(l1_c[3]), .b_i(l1_c[4]), .c_i(w2_p),
                    .s_o(w2_s), .co_o(w4_q));
    popc_fa u_w2_c (.a_i(w2_r), .b_i(w2_s), .c_i(w2_q),
                    .s_o(w2_f), .co_o(w4_r));
    // Weight-4 column: three carries of carries.
    popc_fa u_w4_a (.a_i(w4_p), .b_i(w4_q), .c_i(w4_r),
                    .s_o(w4_f), .co_o(w8_f));

    // Closing row: each column adds its tree bit, the ripple and one.
    logic [COL_N-1:0] col_bit;
    logic [COL_N-1:0] col_sum;
    logic [COL_N:0]   ripple;

    assign col_bit   = {w8_f, w4_f, w2_f, w1_a};
    assign ripple[0] = w1_b;

    for (genvar i = 0; i < COL_N; i++) begin : g_close
        popc_ha_inc u_ha (
            .a_i (col_bit[i]),
            .b_i (ripple[i]),
            .s_o (col_sum[i]),
            .co_o(ripple[i+1])
        );
    end

    // Row result is count + 15 = count - 1 (mod 16); the carry out is
    // the inverse of bit 4 of count - 1. Inverting gives -count.
    assign neg_cnt_o = {ripple[COL_N], ~col_sum};
endmodule

// File: rtl/popc_neg_offset.sv
`timescale 1ns/1ps
module popc_neg_offset
    import popc_pkg::*;
#(
    parameter int BUS_W       = 32,
    parameter int SCALE_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MASK_W-1:0] mask_i,
    input  logic              drive_en_i,
    output logic [BUS_W-1:0]  bus_o,
    output logic              bus_valid_o
);
    localparam int EXT_W = BUS_W - CNT_W - SCALE_SHIFT;
    localparam int TOP_B = SCALE_SHIFT + CNT_W - 1;

    logic [CNT_W-1:0] neg_cnt;
    logic [BUS_W-1:0] offset;
    drv_state_e       state_q, state_d;

    popc_tree u_tree (
        .mask_i   (mask_i),
        .neg_cnt_o(neg_cnt)
    );

    assign offset = {{EXT_W{neg_cnt[CNT_W-1]}}, neg_cnt, {SCALE_SHIFT{1'b0}}};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: if (drive_en_i)  state_d = ST_DRIVE;
            ST_DRIVE: if (!drive_en_i) state_d = ST_QUIET;
            default:  state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_DRIVE: begin
                bus_o       = offset;
                bus_valid_o = 1'b1;
            end
            default: begin
                bus_o       = '0;
                bus_valid_o = 1'b0;
            end
        endcase
    end

    // R2: the enable reaches valid through exactly one register.
    a_r2_valid_follows_en: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en_i |=> bus_valid_o);
    a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en_i |=> !bus_valid_o);
    // R3: quiet bus carries nothing.
    a_r3_zero_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid_o |-> (bus_o == '0));
    // R4: tree result against a direct bit count.
    a_r4_offset_value: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid_o |-> (bus_o == BUS_W'(-((1 << SCALE_SHIFT) * $countones(mask_i)))));
    // R8: word alignment.
    a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        bus_o[SCALE_SHIFT-1:0] == '0);
    // R9: upper bits are a pure sign extension.
    a_r9_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_o[BUS_W-1:TOP_B] == '0) || (bus_o[BUS_W-1:TOP_B] == '1));
endmodule

// File: tb/popc_neg_offset_bench.sv
`timescale 1ns/1ps
module popc_neg_offset_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mask = '0;
    logic        en = 1'b0;
    logic [31:0] bus;
    logic        valid;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #2.5 clk = ~clk;

    popc_neg_offset u_popc_neg_offset (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_i     (mask),
        .drive_en_i (en),
        .bus_o      (bus),
        .bus_valid_o(valid)
    );

    function automatic logic [31:0] ref_off(input logic [15:0] m);
        int n = 0;
        for (int i = 0; i < 16; i++) n += int'(m[i]);
        return 32'(-(4 * n));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // R1: reset state, even with a full mask and enable pending.
    task automatic t_reset();
        mask = 16'hFFFF;
        en   = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 bus in reset", bus, 32'h0);
        check("R1 valid in reset", {31'h0, valid}, 32'h0);
        en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 bus after reset", bus, 32'h0);
        check("R1 valid after reset", {31'h0, valid}, 32'h0);
    endtask

    // R2: enable takes one edge each way.
    task automatic t_enable_timing();
        mask = 16'h0007;
        @(negedge clk);
        en = 1'b1;
        #1;
        check("R2 valid before edge", {31'h0, valid}, 32'h0);
        @(negedge clk);
        check("R2 valid after edge", {31'h0, valid}, 32'h1);
        check("R4 three bits", bus, 32'hFFFF_FFF4);
        en = 1'b0;
        #1;
        check("R2 valid holds until edge", {31'h0, valid}, 32'h1);
        @(negedge clk);
        check("R2 valid dropped", {31'h0, valid}, 32'h0);
    endtask

    // R3: mask activity while quiet leaves the bus at zero.
    task automatic t_quiet_ignores_mask();
        en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            mask = 16'hA5A5 ^ 16'(k * 16'h1111);
            @(negedge clk);
            check("R3 quiet bus", bus, 32'h0);
        end
    endtask

    task automatic t_corners();
        en = 1'b1;
        mask = 16'h0000;
        @(negedge clk);
        check("R5 zero mask", bus, 32'h0000_0000);
        mask = 16'hFFFF;
        #1;
        check("R6 all ones", bus, 32'hFFFF_FFC0);
        mask = 16'h7FFF;
        #1;
        check("R4 fifteen bits", bus, 32'hFFFF_FFC4);
        en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_single_bits();
        en = 1'b1;
        @(negedge clk);
        for (int p = 0; p < 16; p++) begin
            mask = 16'h1 << p;
            #1;
            check($sformatf("R7 single bit %0d", p), bus, 32'hFFFF_FFFC);
            check($sformatf("R8 R9 single bit %0d form", p),
                  {30'h0, bus[1:0]} | {31'h0, !(bus[31:6] == '0 || bus[31:6] == '1)}, 32'h0);
        end
        en = 1'b0;
        @(negedge clk);
    endtask

    // R10 with R4: mask changes between edges reach the bus directly.
    task automatic t_patterns();
        logic [15:0] lfsr = 16'hACE1;
        en = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 40; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mask = lfsr;
            #0.5;
            check($sformatf("R10 R4 pattern %h", lfsr), bus, ref_off(lfsr));
            if (k % 8 == 7) @(negedge clk);
        end
        en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_enable_timing();
        t_quiet_ignores_mask();
        t_corners();
        t_single_bits();
        t_patterns();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule